// File: doc/BRIEF.md
# Three-Channel Timer Register Front End

This block sits between an 8-bit processor bus and three 16-bit timer channels. A 3-bit select code, together with the read/write line, picks one of three control registers, a status register, the three reload latches or the three running counters. Only 8 bits cross the bus at a time. A single shared high-byte holding register makes each 16-bit latch load take effect at once. A shared low-byte capture register makes each 16-bit counter read come from one instant.

The block collects a time-out flag for each channel and forms a masked composite flag, which drives an active-low interrupt line. A flag clears after a status read followed by a read of that channel's counter, and also on a latch load, on a counter initialization from the channel, or on reset. There are two resets. An external reset pin is synchronized on the bus enable strobe and puts every register into its preset state. A software hold bit stops all channels and clears their flags, and leaves latches and control registers alone. The counting logic itself lies outside this block. It is reached through counter-value, time-out and initialization ports.

Top module: `tmrbus_regif`

## Requirements
- R1: A write with select 1 loads control register 2. A write with select 0 loads control register 1 when bit 0 of control register 2 is 1, and control register 3 when that bit is 0. The `ctrl_q` output packs register 1 in bits 7:0, register 2 in bits 15:8 and register 3 in bits 23:16.
- R2: A read with select 0 returns 0x00 and changes no state.
- R3: Channel k (k=1..3) owns select codes 2k (even) and 2k+1 (odd). A write to any even code stores the byte in one holding register shared by all channels. A write to the odd code loads channel k's latch with {holding byte, written byte} in a single step.
- R4: A read at channel k's even code returns bits 15:8 of its counter input and captures bits 7:0 into a shared register. A later read at the odd code returns that captured byte, whatever the counter input is then.
- R5: A read with select 1 returns the status byte. Bits 2:0 are the channel 3..1 flags (bit 0 is channel 1), bits 6:3 are zero, and bit 7 is the composite flag.
- R6: The composite flag is the OR over channels of (flag AND bit 6 of that channel's control register). `irq_n` is low exactly when the composite flag is 1.
- R7: A channel's flag clears when its counter is read at the even code, provided a status read has already been made while the flag was set. A counter read without such a prior status read leaves the flag set. The flag also clears on a latch load of that channel and on a pulse of that channel's `init_evt` bit.
- R8: A recognized hardware reset sets every latch to 0xFFFF and sets all control bits to 0, except bit 0 of control register 1, which becomes 1. It also clears flags and both byte registers.
- R9: While bit 0 of control register 1 is 1, `hold_preset` is high and all flags are forced to 0 and stay at 0. Latches and control registers can still be written.
- R10: All state advances only on cycles where `en` is high. `ext_rst_n` is sampled through two `en` cycles and takes effect on the third `en` cycle it is low.
- R11: A pulse on a channel's `tmo` bit during an `en` cycle sets that channel's flag, unless the hold is active. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| en | input | 1 | Bus enable strobe; qualifies every state update |
| ext_rst_n | input | 1 | External timer reset pin, active low, asynchronous |
| cs | input | 1 | Chip select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| sel | input | 3 | Register select code |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte (0 when not reading) |
| irq_n | output | 1 | Interrupt request, active low |
| cnt_in | input | 48 | Counter values of channels 3..1, 16 bits each, channel 1 in bits 15:0 |
| tmo | input | 3 | Time-out pulse per channel |
| init_evt | input | 3 | Counter initialization pulse per channel |
| latch_q | output | 48 | Latch contents of channels 3..1, channel 1 in bits 15:0 |
| ctrl_q | output | 24 | Control registers 3..1, register 1 in bits 7:0 |
| latch_wr | output | 3 | One-cycle strobe per channel on a latch load |
| hold_preset | output | 1 | High while any reset holds the channels in preset |

## Verification
The bench tests the shared holding byte across channels. It loads the high byte through channel 3's even code and the low byte through channel 1's odd code. A design with a separate buffer per channel would leave a stale high byte in channel 1. It changes the counter input between the two halves of a counter read, so a design that reads the low byte live would return the new value instead of the captured one. For the flag clear sequence it checks three cases: a counter read without a prior status read, a status read made while the flag was clear, and the proper sequence. A design that skips the arming step would drop interrupts early. The reset test counts `en` pulses one at a time with `en` held low in between, which catches a synchronizer of the wrong depth or one that runs on the system clock.

// File: rtl/tmrbus_pkg.sv
package tmrbus_pkg;
  localparam int NTMR     = 3;
  localparam int MASK_BIT = 6;
  localparam int HOLD_BIT = 0;
  localparam int ADDR_BIT = 0;

  typedef struct packed {
    logic            wr_cr2;
    logic            wr_cr13;
    logic            rd_status;
    logic            wr_hi;
    logic [NTMR-1:0] wr_lo;
    logic [NTMR-1:0] rd_hi;
    logic [NTMR-1:0] rd_lo;
  } acc_t;

  function automatic logic composite(input logic [NTMR-1:0] flags,
                                     input logic [NTMR-1:0] masks);
    return |(flags & masks);
  endfunction

  function automatic logic [1:0] chan_code(input int idx);
    return 2'(idx + 1);
  endfunction
endpackage

// File: rtl/tmrbus_rst_sync.sv
module tmrbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pin_n,
  output logic hw_rst
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else if (en) begin
      s1_q <= pin_n;
      s2_q <= s1_q;
    end
  end

  assign hw_rst = ~s2_q;
endmodule

// File: rtl/tmrbus_decode.sv
module tmrbus_decode import tmrbus_pkg::*; (
  input  logic       strobe,
  input  logic       rw,
  input  logic [2:0] sel,
  output acc_t       acc
);
  always_comb begin
    acc           = '0;
    acc.wr_cr13   = strobe & ~rw & (sel == 3'd0);
    acc.wr_cr2    = strobe & ~rw & (sel == 3'd1);
    acc.rd_status = strobe &  rw & (sel == 3'd1);
    acc.wr_hi     = strobe & ~rw & ~sel[0] & (sel[2:1] != 2'd0);
    for (int i = 0; i < NTMR; i++) begin
      if (sel[2:1] == chan_code(i)) begin
        acc.wr_lo[i] = strobe & ~rw &  sel[0];
        acc.rd_hi[i] = strobe &  rw & ~sel[0];
        acc.rd_lo[i] = strobe &  rw &  sel[0];
      end
    end
  end
endmodule

// File: rtl/tmrbus_flag.sv
module tmrbus_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hold,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic rd_stat,
  input  logic rd_cnt,
  output logic flag_q,
  output logic armed_q
);
  logic flag_d, armed_d;

  always_comb begin
    flag_d = flag_q;
    if (hold)                          flag_d = 1'b0;
    else if (set_ev)                   flag_d = 1'b1;
    else if (clr_ev || (rd_cnt && armed_q)) flag_d = 1'b0;
    armed_d = flag_d ? (armed_q | (rd_stat & flag_q)) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (en) begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/tmrbus_regif.sv
module tmrbus_regif import tmrbus_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       ext_rst_n,
  input  logic                       cs,
  input  logic                       rw,
  input  logic [2:0]                 sel,
  input  logic [BYTE_W-1:0]          wdata,
  output logic [BYTE_W-1:0]          rdata,
  output logic                       irq_n,
  input  logic [NTMR*2*BYTE_W-1:0]   cnt_in,
  input  logic [NTMR-1:0]            tmo,
  input  logic [NTMR-1:0]            init_evt,
  output logic [NTMR*2*BYTE_W-1:0]   latch_q,
  output logic [NTMR*BYTE_W-1:0]     ctrl_q,
  output logic [NTMR-1:0]            latch_wr,
  output logic                       hold_preset
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int PAD_W  = BYTE_W - 1 - NTMR;

  logic [NTMR-1:0][BYTE_W-1:0] cr_q;
  logic [NTMR-1:0][WORD_W-1:0] lat_q;
  logic [NTMR-1:0][WORD_W-1:0] cnt_w;
  logic [BYTE_W-1:0]           hi_buf_q, lo_buf_q;
  logic [NTMR-1:0]             flag_q, armed_q, mask_w;
  logic [NTMR-1:0]             rd_hi_ev;
  logic                        rd_status_ev, hw_rst, comp;
  logic [BYTE_W-1:0]           stat;
  acc_t                        acc;

  tmrbus_rst_sync u_sync (
    .clk(clk), .rst_n(rst_n), .en(en), .pin_n(ext_rst_n), .hw_rst(hw_rst)
  );

  tmrbus_decode u_dec (.strobe(cs & en), .rw(rw), .sel(sel), .acc(acc));

  assign rd_hi_ev     = acc.rd_hi;
  assign rd_status_ev = acc.rd_status;
  assign hold_preset  = hw_rst | cr_q[0][HOLD_BIT];
  assign latch_wr     = acc.wr_lo & {NTMR{~hw_rst}};

  for (genvar i = 0; i < NTMR; i++) begin : g_ch
    assign cnt_w[i]  = cnt_in[i*WORD_W +: WORD_W];
    assign mask_w[i] = cr_q[i][MASK_BIT];
    tmrbus_flag u_flag (
      .clk(clk), .rst_n(rst_n), .en(en), .hold(hold_preset),
      .set_ev(tmo[i]), .clr_ev(latch_wr[i] | init_evt[i]),
      .rd_stat(acc.rd_status), .rd_cnt(acc.rd_hi[i]),
      .flag_q(flag_q[i]), .armed_q(armed_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q    <= '1;
      cr_q     <= '0;
      cr_q[0][HOLD_BIT] <= 1'b1;
      hi_buf_q <= '0;
      lo_buf_q <= '0;
    end else if (en) begin
      if (hw_rst) begin
        lat_q    <= '1;
        cr_q     <= '0;
        cr_q[0][HOLD_BIT] <= 1'b1;
        hi_buf_q <= '0;
        lo_buf_q <= '0;
      end else begin
        if (acc.wr_cr2) cr_q[1] <= wdata;
        if (acc.wr_cr13) begin
          if (cr_q[1][ADDR_BIT]) cr_q[0] <= wdata;
          else                   cr_q[2] <= wdata;
        end
        if (acc.wr_hi) hi_buf_q <= wdata;
        for (int i = 0; i < NTMR; i++) begin
          if (acc.wr_lo[i]) lat_q[i] <= {hi_buf_q, wdata};
          if (acc.rd_hi[i]) lo_buf_q <= cnt_w[i][BYTE_W-1:0];
        end
      end
    end
  end

  assign comp  = composite(flag_q, mask_w);
  assign stat  = {comp, {PAD_W{1'b0}}, flag_q};
  assign irq_n = ~comp;

  always_comb begin
    rdata = '0;
    if (acc.rd_status) rdata = stat;
    for (int i = 0; i < NTMR; i++) begin
      if (acc.rd_hi[i]) rdata = cnt_w[i][WORD_W-1:BYTE_W];
      if (acc.rd_lo[i]) rdata = lo_buf_q;
    end
  end

  assign latch_q = lat_q;
  assign ctrl_q  = cr_q;
endmodule

// File: rtl/tmrbus_regif_chk.sv
module tmrbus_regif_chk import tmrbus_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en,
  input logic                     cs,
  input logic                     rw,
  input logic [2:0]               sel,
  input logic [BYTE_W-1:0]        wdata,
  input logic [BYTE_W-1:0]        rdata,
  input logic                     irq_n,
  input logic [NTMR-1:0]          tmo,
  input logic [NTMR*2*BYTE_W-1:0] latch_q,
  input logic [NTMR*BYTE_W-1:0]   ctrl_q,
  input logic                     hold_preset,
  input logic                     hw_rst,
  input logic [NTMR-1:0]          flag_q,
  input logic [NTMR-1:0]          armed_q,
  input logic [NTMR-1:0]          rd_hi_ev
);
  localparam int WORD_W = 2 * BYTE_W;

  // R6: interrupt only with a flag pending
  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flag_q != '0));

  // R5: status padding bits read zero
  p_status_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && en && rw && sel == 3'd1) |-> (rdata[BYTE_W-2:NTMR] == '0));

  // R8: recognized hardware reset presets latches and control
  p_hw_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hw_rst) |=> (latch_q == '1 &&
                        ctrl_q == {{(NTMR*BYTE_W-1){1'b0}}, 1'b1}));

  // R9: hold keeps flags cleared
  p_hold_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hold_preset) |=> (flag_q == '0));

  for (genvar i = 0; i < NTMR; i++) begin : g_a
    // R7: armed counter read clears the flag
    p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rd_hi_ev[i] && armed_q[i] && !tmo[i]) |=> !flag_q[i]);

    // R11: time-out sets the flag outside hold
    p_tmo_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tmo[i] && !hold_preset) |=> flag_q[i]);

    // R3: odd-code write lands in the low byte of that latch
    p_latch_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cs && !rw && !hw_rst && sel == {chan_code(i), 1'b1})
      |=> (latch_q[i*WORD_W +: BYTE_W] == $past(wdata)));
  end
endmodule

bind tmrbus_regif tmrbus_regif_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cs(cs), .rw(rw), .sel(sel),
  .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .tmo(tmo),
  .latch_q(latch_q), .ctrl_q(ctrl_q), .hold_preset(hold_preset),
  .hw_rst(hw_rst), .flag_q(flag_q), .armed_q(armed_q), .rd_hi_ev(rd_hi_ev)
);

// File: tb/tmrbus_regif_test.sv
module tmrbus_regif_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, en = 1'b1, ext_rst_n = 1'b1;
  logic        cs = 1'b0, rw = 1'b1;
  logic [2:0]  sel = 3'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        irq_n, hold_preset;
  logic [47:0] cnt_in = '0, latch_q;
  logic [23:0] ctrl_q;
  logic [2:0]  tmo = '0, init_evt = '0, latch_wr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  tmrbus_regif uut (
    .clk(clk), .rst_n(rst_n), .en(en), .ext_rst_n(ext_rst_n),
    .cs(cs), .rw(rw), .sel(sel), .wdata(wdata), .rdata(rdata),
    .irq_n(irq_n), .cnt_in(cnt_in), .tmo(tmo), .init_evt(init_evt),
    .latch_q(latch_q), .ctrl_q(ctrl_q), .latch_wr(latch_wr),
    .hold_preset(hold_preset)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard
  always begin
    @(negedge clk);
    #1;
    if (cs && rw && en) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard empty actual=%h expected=none", rdata);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(64'(rdata), 64'(e), t);
      end
    end
  end

  task automatic rd(input logic [2:0] s, input logic [7:0] e, input string t);
    @(negedge clk);
    cs = 1'b1; rw = 1'b1; sel = s;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rw = 1'b0; sel = s; wdata = d;
    @(negedge clk);
    cs = 1'b0; rw = 1'b1;
  endtask

  task automatic pulse(input logic [2:0] t, input logic [2:0] ie);
    @(negedge clk);
    tmo = t; init_evt = ie;
    @(negedge clk);
    tmo = '0; init_evt = '0;
  endtask

  task automatic en_pulse();
    @(negedge clk); en = 1'b1;
    @(negedge clk); en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(64'(latch_q), 64'({3{16'hFFFF}}), "R8 latches after reset");
    chk(64'(ctrl_q), 64'(24'h000001), "R8 control after reset");
    chk(64'(irq_n), 64'(1), "R6 irq idle after reset");
    chk(64'(hold_preset), 64'(1), "R9 hold after reset");
    rd(3'd1, 8'h00, "R5 status after reset");

    wr(3'd0, 8'h41);
    chk(64'(ctrl_q), 64'(24'h410001), "R1 select0 goes to cr3");
    wr(3'd1, 8'h41);
    wr(3'd0, 8'h40);
    chk(64'(ctrl_q), 64'(24'h414140), "R1 select0 goes to cr1");
    chk(64'(hold_preset), 64'(0), "R9 hold released");

    wr(3'd2, 8'h12); wr(3'd3, 8'h34);
    wr(3'd4, 8'hA5); wr(3'd5, 8'h3C);
    chk(64'(latch_q), 64'({16'hFFFF, 16'hA53C, 16'h1234}), "R3 latch pair writes");
    wr(3'd6, 8'h77); wr(3'd3, 8'h55);
    chk(64'(latch_q), 64'({16'hFFFF, 16'hA53C, 16'h7755}), "R3 shared high buffer");

    cnt_in = {16'hBEEF, 16'h1111, 16'h2222};
    rd(3'd6, 8'hBE, "R4 counter high byte");
    cnt_in = '0;
    rd(3'd7, 8'hEF, "R4 captured low byte");
    rd(3'd0, 8'h00, "R2 select0 read");
    chk(64'(ctrl_q), 64'(24'h414140), "R2 no effect on control");

    pulse(3'b010, 3'b000);
    chk(64'(irq_n), 64'(0), "R11 R6 flag raises irq");
    rd(3'd4, 8'h00, "R7 unarmed counter read");
    chk(64'(irq_n), 64'(0), "R7 flag kept without status read");
    rd(3'd1, 8'h82, "R5 status one flag");
    rd(3'd4, 8'h00, "R7 armed counter read");
    chk(64'(irq_n), 64'(1), "R7 flag cleared by sequence");
    rd(3'd1, 8'h00, "R7 status after clear");

    pulse(3'b010, 3'b000);
    rd(3'd4, 8'h00, "R7 stale arm read");
    chk(64'(irq_n), 64'(0), "R7 stale arm ignored");
    wr(3'd1, 8'h01);
    chk(64'(irq_n), 64'(1), "R6 mask hides flag");
    rd(3'd1, 8'h02, "R5 masked status");
    wr(3'd1, 8'h41);
    chk(64'(irq_n), 64'(0), "R6 mask restored");
    wr(3'd4, 8'hA5); wr(3'd5, 8'h3C);
    chk(64'(irq_n), 64'(1), "R7 latch write clears");
    rd(3'd1, 8'h00, "R7 status after latch write");

    pulse(3'b100, 3'b000);
    rd(3'd1, 8'h84, "R11 R5 timer3 flag");
    pulse(3'b000, 3'b100);
    rd(3'd1, 8'h00, "R7 init event clears");
    pulse(3'b001, 3'b000);
    rd(3'd1, 8'h81, "R11 R5 timer1 flag");

    wr(3'd0, 8'h41);
    chk(64'(hold_preset), 64'(1), "R9 hold bit set");
    rd(3'd1, 8'h00, "R9 flags cleared in hold");
    pulse(3'b001, 3'b000);
    rd(3'd1, 8'h00, "R9 time-out ignored in hold");
    wr(3'd2, 8'h0A); wr(3'd3, 8'h0B);
    chk(64'(latch_q), 64'({16'hFFFF, 16'hA53C, 16'h0A0B}), "R9 latch writable in hold");
    wr(3'd0, 8'h40);
    chk(64'(ctrl_q), 64'(24'h414140), "R9 control writable in hold");

    @(negedge clk); en = 1'b0; ext_rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(64'(latch_q), 64'({16'hFFFF, 16'hA53C, 16'h0A0B}), "R10 no action without en");
    en_pulse();
    chk(64'(ctrl_q), 64'(24'h414140), "R10 first en pulse");
    en_pulse();
    chk(64'(ctrl_q), 64'(24'h414140), "R10 second en pulse");
    en_pulse();
    chk(64'(latch_q), 64'({3{16'hFFFF}}), "R10 R8 reset at third pulse");
    chk(64'(ctrl_q), 64'(24'h000001), "R10 R8 control preset");
    @(negedge clk); ext_rst_n = 1'b1; en = 1'b1;
    repeat (4) @(negedge clk);
    chk(64'(hold_preset), 64'(1), "R8 hold after hardware reset");
    chk(64'(irq_n), 64'(1), "R8 irq idle after hardware reset");

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule